// File: doc/BRIEF.md
# Shifter-ALU with Flag Update

This block is the combinational data path of a 32-bit integer core. The second operand goes through a barrel shifter first. The shifter produces its own carry-out and can use the incoming carry flag. The shifted value then meets the first operand in one of two places: a bitwise unit (AND, OR, XOR, move, move-inverted) or an adder (add, add-with-carry, subtract). From the outcome the block works out the next negative, zero, carry and overflow flags.

The main point is where the carry flag comes from, and this depends on the class of operation. A bitwise operation loads the carry from the shifter's carry-out and leaves overflow alone. An arithmetic operation loads both carry and overflow from the adder and discards the shifter's carry-out. The shift count comes either from a 5-bit field in the instruction or from a register. For a register count, only the low byte of that register is read, as an unsigned number, so counts of 32 and above need defined results.

When the set-flags control is low, all four flags pass through unchanged. Instruction decode, condition checks and register or PC write-back are left to the surrounding core.

Top module: `shifter_alu`

## Requirements
- R1: Opcode codes 0, 1, 2, 3 and 7 select bitwise AND, OR, XOR, move and move-inverted of operand A with the shifted operand B. The result is that bitwise value.
- R2: Opcode 4 gives A plus shifted B with carry-in 0. Opcode 5 gives A plus shifted B plus the incoming carry flag. Opcode 6 gives A plus the inverse of shifted B plus 1, which is A minus shifted B.
- R3: Shift kind codes are 0 left logical, 1 right logical, 2 right arithmetic and 3 rotate right. For a count of 1 to 31, the carry-out is the last bit shifted out.
- R4: When the register count is selected, only bits 7:0 of the count register are used, as an unsigned number. The upper bits have no effect.
- R5: A left or right logical shift by exactly 32 gives zero, with carry-out equal to bit 0 (left) or bit 31 (right). Counts above 32 give zero with carry-out 0.
- R6: An arithmetic right shift by 32 or more fills every bit with bit 31 of the operand, and the carry-out equals that bit.
- R7: A rotate by a nonzero count rotates by the count modulo 32, and the carry-out equals bit 31 of the rotated value. This also covers counts of 32 and 64.
- R8: A count of 0 passes operand B through unchanged, with carry-out equal to the incoming carry. The exception is an immediate rotate with count 0: it rotates right by one through the carry, with the old carry entering bit 31 and bit 0 becoming the carry-out.
- R9: For a bitwise opcode with set-flags high, the carry flag becomes the shifter carry-out and the overflow flag keeps its incoming value.
- R10: For an arithmetic opcode with set-flags high, the carry flag becomes the adder's carry-out. The overflow flag is set when both adder inputs share a sign and the sum's sign differs from it. The shifter carry-out is ignored.
- R11: With set-flags high, N becomes result bit 31 and Z is set exactly when the full 32-bit result is zero. The flag vectors are ordered {N,Z,C,V} from bit 3 down to bit 0.
- R12: With set-flags low, the flag output equals the flag input on all four bits, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand, fed unshifted |
| opnd_b | input | 32 | Second operand, passed through the shifter |
| shift_kind | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate |
| shamt_imm | input | 5 | Count from the instruction field |
| shamt_reg | input | 32 | Register holding the count; only bits 7:0 are used |
| amt_from_reg | input | 1 | 1 selects the register count, 0 the immediate count |
| opcode | input | 3 | Operation code, see R1 and R2 |
| flags_in | input | 4 | Current {N,Z,C,V} |
| set_flags | input | 1 | 1 lets the flags update |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The in-line checks assume every input is a settled two-state value and that the datapath width is a power of two that fits in the 8-bit count. They are written so that any such input combination is legal, which lets the stimulus range freely. The random part draws opcode, shift kind, flags and set-flags uniformly. It takes counts from a biased pool (0, 1, 3, 31, 32, 33, 64, random bytes) and fills the upper bits of the count register with random junk, so that every property's trigger condition is hit often.

// File: rtl/shalu_pkg.sv
// Package: shared encodings for the shifter-ALU.
// Assumes flags are carried as a 4-bit vector {N,Z,C,V}.
package shalu_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ORR = 3'd1,
        OP_EOR = 3'd2,
        OP_MOV = 3'd3,
        OP_ADD = 3'd4,
        OP_ADC = 3'd5,
        OP_SUB = 3'd6,
        OP_MVN = 3'd7
    } alu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // True for opcodes that go through the adder
    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/shift_unit.sv
// Barrel shifter with carry-out.
// Does: left/right logical, right arithmetic, rotate, and rotate-through-carry
// for an immediate rotate of zero. Assumes W is a power of two and W fits in
// AMT_W bits; the count is unsigned.
module shift_unit
    import shalu_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 5
) (
    input  logic [W-1:0]     x,
    input  shift_kind_e      kind,
    input  logic [AMT_W-1:0] amt_reg,
    input  logic [IMM_W-1:0] amt_imm,
    input  logic             use_reg,
    input  logic             c_in,
    output logic [W-1:0]     y,
    output logic             c_out
);
    localparam int RW = $clog2(W);

    logic [AMT_W-1:0] amt;
    logic             rrx;
    logic [W:0]       lsl_ext;
    logic [W:0]       lsr_ext;
    logic [AMT_W-1:0] asr_amt;
    logic [W:0]       asr_ext;
    logic [W-1:0]     rot [0:RW];

    // Select the count source and spot the rotate-through-carry case
    always_comb begin
        amt = use_reg ? amt_reg : AMT_W'(amt_imm);
        rrx = !use_reg && (kind == SH_ROR) && (amt_imm == '0);
    end

    // Widened logical and saturated arithmetic shifts; the extra bit holds carry
    always_comb begin
        lsl_ext = {1'b0, x} << amt;
        lsr_ext = {x, 1'b0} >> amt;
        asr_amt = (amt > AMT_W'(W)) ? AMT_W'(W) : amt;
        asr_ext = $unsigned($signed({x, 1'b0}) >>> asr_amt);
    end

    // Log-depth rotator: stage k rotates by 2**k when count bit k is set
    assign rot[0] = x;
    for (genvar k = 0; k < RW; k++) begin : g_rot
        localparam int SH = 1 << k;
        assign rot[k+1] = amt[k] ? {rot[k][SH-1:0], rot[k][W-1:SH]} : rot[k];
    end

    // Final selection of value and carry-out
    always_comb begin
        y     = x;
        c_out = c_in;
        if (amt == '0) begin
            if (rrx) begin
                y     = {c_in, x[W-1:1]};
                c_out = x[0];
            end
        end else begin
            unique case (kind)
                SH_LSL: begin y = lsl_ext[W-1:0]; c_out = lsl_ext[W]; end
                SH_LSR: begin y = lsr_ext[W:1];   c_out = lsr_ext[0]; end
                SH_ASR: begin y = asr_ext[W:1];   c_out = asr_ext[0]; end
                SH_ROR: begin y = rot[RW];        c_out = rot[RW][W-1]; end
                default: begin y = x; c_out = c_in; end
            endcase
        end
    end

    // Guard: rotate carry agrees with the rotated value, and wide logical shifts clear everything
    always_comb begin
        if (kind == SH_ROR && amt != '0) begin
            // R7
            ror_carry_chk: assert (c_out == y[W-1])
                else $error("rotate carry differs from bit %0d", W-1);
        end
        if ((kind == SH_LSL || kind == SH_LSR) && amt > AMT_W'(W)) begin
            // R5
            wide_shift_chk: assert (y == '0 && !c_out)
                else $error("logical shift beyond width left residue");
        end
        if (kind == SH_ASR && amt >= AMT_W'(W)) begin
            // R6
            asr_fill_chk: assert (c_out == x[W-1] && (y == '0 || y == '1))
                else $error("arithmetic shift beyond width not sign-filled");
        end
    end
endmodule

// File: rtl/logic_unit.sv
// Bitwise unit: AND, OR, XOR, move, move-inverted of a with shifted b.
// Assumes the caller ignores its output for arithmetic opcodes.
module logic_unit
    import shalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // Per-opcode bitwise selection
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_ORR:  y = a | b;
            OP_EOR:  y = a ^ b;
            OP_MVN:  y = ~b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/adder_unit.sv
// Adder for add, add-with-carry and subtract, with carry and overflow.
// Subtract is done as a plus inverted b plus one. Assumes op is arithmetic
// whenever its outputs are used.
module adder_unit
    import shalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         c_in,
    output logic [W-1:0] y,
    output logic         c_out,
    output logic         v_out
);
    logic [W-1:0] b_eff;
    logic         cin_eff;
    logic [W:0]   sum;

    // Pick operand polarity and carry-in per opcode
    always_comb begin
        b_eff   = (op == OP_SUB) ? ~b : b;
        cin_eff = (op == OP_SUB) ? 1'b1 : ((op == OP_ADC) ? c_in : 1'b0);
    end

    // One wide add; top bit is carry-out, signs give overflow
    always_comb begin
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
        y     = sum[W-1:0];
        c_out = sum[W];
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

    // Guard: subtracting a value from itself gives zero with no borrow
    always_comb begin
        if (op == OP_SUB && a == b) begin
            // R2
            sub_self_chk: assert (y == '0 && c_out && !v_out)
                else $error("self subtraction wrong");
        end
        if (op == OP_ADD && b == '0) begin
            // R10
            add_zero_chk: assert (y == a && !c_out && !v_out)
                else $error("adding zero changed flags or value");
        end
    end
endmodule

// File: rtl/flag_unit.sv
// Next-flag logic: N and Z from the result, C and V from the source picked by
// the opcode class, all held when set_flags is low. Flags are {N,Z,C,V}.
module flag_unit
    import shalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         is_arith,
    input  logic         sh_c,
    input  logic         add_c,
    input  logic         add_v,
    input  logic         set_flags,
    input  logic [3:0]   flags_in,
    output logic [3:0]   flags_out
);
    // Compute or hold the four flags
    always_comb begin
        flags_out = flags_in;
        if (set_flags) begin
            flags_out[FLAG_N] = res[W-1];
            flags_out[FLAG_Z] = (res == '0);
            flags_out[FLAG_C] = is_arith ? add_c : sh_c;
            flags_out[FLAG_V] = is_arith ? add_v : flags_in[FLAG_V];
        end
    end

    // Guard: hold behaviour and bitwise-class carry/overflow sources
    always_comb begin
        if (!set_flags) begin
            // R12
            flag_hold_chk: assert (flags_out == flags_in)
                else $error("flags moved with set_flags low");
        end
        if (set_flags && !is_arith) begin
            // R9
            logic_cv_chk: assert (flags_out[FLAG_V] == flags_in[FLAG_V] && flags_out[FLAG_C] == sh_c)
                else $error("bitwise op took wrong C/V source");
        end
    end
endmodule

// File: rtl/shifter_alu.sv
// Top: shifter feeding a bitwise unit and an adder, then flag update.
// Purely combinational. Assumes W is a power of two not above 2**AMT_W - 1.
module shifter_alu
    import shalu_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int IMM_W = 5
) (
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [1:0]       shift_kind,
    input  logic [IMM_W-1:0] shamt_imm,
    input  logic [W-1:0]     shamt_reg,
    input  logic             amt_from_reg,
    input  logic [2:0]       opcode,
    input  logic [3:0]       flags_in,
    input  logic             set_flags,
    output logic [W-1:0]     result,
    output logic [3:0]       flags_out
);
    alu_op_e      op;
    shift_kind_e  kind;
    logic [W-1:0] sh_y;
    logic         sh_c;
    logic [W-1:0] log_y;
    logic [W-1:0] add_y;
    logic         add_c;
    logic         add_v;
    logic         arith;
    logic         amt_hi_unused;

    // Decode raw port codes into package types
    always_comb begin
        op    = alu_op_e'(opcode);
        kind  = shift_kind_e'(shift_kind);
        arith = op_is_arith(op);
    end

    assign amt_hi_unused = ^shamt_reg[W-1:AMT_W];

    shift_unit #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) u_shift (
        .x       (opnd_b),
        .kind    (kind),
        .amt_reg (shamt_reg[AMT_W-1:0]),
        .amt_imm (shamt_imm),
        .use_reg (amt_from_reg),
        .c_in    (flags_in[FLAG_C]),
        .y       (sh_y),
        .c_out   (sh_c)
    );

    logic_unit #(.W(W)) u_logic (
        .a  (opnd_a),
        .b  (sh_y),
        .op (op),
        .y  (log_y)
    );

    adder_unit #(.W(W)) u_add (
        .a     (opnd_a),
        .b     (sh_y),
        .op    (op),
        .c_in  (flags_in[FLAG_C]),
        .y     (add_y),
        .c_out (add_c),
        .v_out (add_v)
    );

    // Route the class-appropriate value to the result
    always_comb begin
        result = arith ? add_y : log_y;
    end

    flag_unit #(.W(W)) u_flags (
        .res       (result),
        .is_arith  (arith),
        .sh_c      (sh_c),
        .add_c     (add_c),
        .add_v     (add_v),
        .set_flags (set_flags),
        .flags_in  (flags_in),
        .flags_out (flags_out)
    );

    // Guard: N and Z track the result port when flags update
    always_comb begin
        if (set_flags) begin
            // R11
            nz_track_chk: assert (flags_out[FLAG_N] == result[W-1] && (flags_out[FLAG_Z] == (result == '0)))
                else $error("N/Z disagree with result");
        end
    end
endmodule

// File: tb/tb_shifter_alu.sv
module tb_shifter_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a, opnd_b, shamt_reg, result;
    logic [1:0]  shift_kind;
    logic [4:0]  shamt_imm;
    logic        amt_from_reg, set_flags;
    logic [2:0]  opcode;
    logic [3:0]  flags_in, flags_out;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    shifter_alu dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shift_kind(shift_kind),
        .shamt_imm(shamt_imm), .shamt_reg(shamt_reg), .amt_from_reg(amt_from_reg),
        .opcode(opcode), .flags_in(flags_in), .set_flags(set_flags),
        .result(result), .flags_out(flags_out)
    );

    // Reference shifter: returns {carry, value}
    function automatic logic [32:0] ref_shift(logic [31:0] x, logic [1:0] k, int n, bit imm, logic cin);
        logic [31:0] r;
        logic        c;
        int          m;
        if (imm && k == 2'd3 && n == 0) return {x[0], cin, x[31:1]};
        if (n == 0) return {cin, x};
        r = '0;
        c = 1'b0;
        case (k)
            2'd0: if (n < 32) begin r = x << n; c = x[32-n]; end
                  else if (n == 32) begin r = '0; c = x[0]; end
            2'd1: if (n < 32) begin r = x >> n; c = x[n-1]; end
                  else if (n == 32) begin r = '0; c = x[31]; end
            2'd2: if (n < 32) begin r = $unsigned($signed(x) >>> n); c = x[n-1]; end
                  else begin r = {32{x[31]}}; c = x[31]; end
            default: begin
                m = n % 32;
                for (int i = 0; i < 32; i++) r[i] = x[(i + m) % 32];
                c = r[31];
            end
        endcase
        return {c, r};
    endfunction

    // Reference data path: returns {flags, result}
    function automatic logic [35:0] ref_alu(logic [31:0] a, logic [31:0] b, logic [1:0] k,
                                            logic [4:0] imm, logic [31:0] rg, bit ur,
                                            logic [2:0] op, logic [3:0] fl, bit sf);
        logic [32:0] sh;
        logic [31:0] s, b2, res;
        logic [32:0] sum;
        logic        c, v, cin;
        int          n;
        n  = ur ? int'(rg[7:0]) : int'(imm);
        sh = ref_shift(b, k, n, !ur, fl[1]);
        s  = sh[31:0];
        c  = sh[32];
        v  = fl[0];
        case (op)
            3'd0: res = a & s;
            3'd1: res = a | s;
            3'd2: res = a ^ s;
            3'd3: res = s;
            3'd7: res = ~s;
            default: begin
                b2  = (op == 3'd6) ? ~s : s;
                cin = (op == 3'd6) ? 1'b1 : ((op == 3'd5) ? fl[1] : 1'b0);
                sum = {1'b0, a} + {1'b0, b2} + 33'(cin);
                res = sum[31:0];
                c   = sum[32];
                v   = (a[31] == b2[31]) && (res[31] != a[31]);
            end
        endcase
        if (!sf) return {fl, res};
        return {res[31], res == 0, c, v, res};
    endfunction

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [1:0] k, logic [4:0] imm,
                         logic [31:0] rg, bit ur, logic [2:0] op, logic [3:0] fl, bit sf,
                         string req);
        logic [35:0] exp;
        @(posedge clk);
        opnd_a = a; opnd_b = b; shift_kind = k; shamt_imm = imm; shamt_reg = rg;
        amt_from_reg = ur; opcode = op; flags_in = fl; set_flags = sf;
        exp = ref_alu(a, b, k, imm, rg, ur, op, fl, sf);
        @(negedge clk);
        n_checks++;
        if ({flags_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d kind=%0d ur=%0d amt=%0d/%0d got flags=%b res=%h exp flags=%b res=%h",
                     req, op, k, ur, imm, rg[7:0], flags_out, result, exp[35:32], exp[31:0]);
        end
    endtask

    function automatic logic [31:0] pick_amt();
        case ($urandom % 8)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'd3;
            3: return 32'd31;
            4: return 32'd32;
            5: return 32'd33;
            6: return 32'd64;
            default: return 32'($urandom % 256);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        opnd_a = 0; opnd_b = 0; shift_kind = 0; shamt_imm = 0; shamt_reg = 0;
        amt_from_reg = 0; opcode = 0; flags_in = 0; set_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (result !== 32'h0 || flags_out !== 4'h0) begin
            n_fail++;
            $display("FAIL R12 reset state: got res=%h flags=%b expected 0/0000", result, flags_out);
        end
        rst_n = 1'b1;

        // R1 bitwise opcodes
        for (int op = 0; op < 8; op++)
            if (op < 4 || op == 7)
                apply(32'hF0F0_1234, 32'h0FF0_AAAA, 2'd0, 5'd0, 0, 0, 3'(op), 4'b0000, 1, "R1");
        // R2 arithmetic opcodes
        apply(32'h7FFF_FFFF, 32'h1, 2'd0, 5'd0, 0, 0, 3'd4, 4'b0000, 1, "R2");
        apply(32'hFFFF_FFFF, 32'h1, 2'd0, 5'd0, 0, 0, 3'd5, 4'b0010, 1, "R2");
        apply(32'h0000_0005, 32'h7, 2'd0, 5'd0, 0, 0, 3'd6, 4'b0000, 1, "R2");
        apply(32'h8000_0000, 32'h1, 2'd0, 5'd0, 0, 0, 3'd6, 4'b0000, 1, "R2");
        // R3 each kind by an immediate count of 3
        for (int k = 0; k < 4; k++)
            apply(32'h0, 32'h8000_0005, 2'(k), 5'd3, 0, 0, 3'd3, 4'b0000, 1, "R3");
        // R4 junk in upper bits of the count register
        apply(32'h0, 32'h1234_5678, 2'd1, 5'd0, 32'hABCD_EF04, 1, 3'd3, 4'b0000, 1, "R4");
        apply(32'h0, 32'h1234_5678, 2'd0, 5'd0, 32'hFFFF_FF00, 1, 3'd3, 4'b0010, 1, "R4");
        // R5 logical shifts at and beyond the width
        apply(32'h0, 32'h8000_0001, 2'd0, 5'd0, 32'd32, 1, 3'd3, 4'b0000, 1, "R5");
        apply(32'h0, 32'h8000_0001, 2'd1, 5'd0, 32'd32, 1, 3'd3, 4'b0000, 1, "R5");
        apply(32'h0, 32'hFFFF_FFFF, 2'd0, 5'd0, 32'd33, 1, 3'd3, 4'b0010, 1, "R5");
        apply(32'h0, 32'hFFFF_FFFF, 2'd1, 5'd0, 32'd200, 1, 3'd3, 4'b0010, 1, "R5");
        // R6 arithmetic shift saturation
        apply(32'h0, 32'h8000_0000, 2'd2, 5'd0, 32'd32, 1, 3'd3, 4'b0000, 1, "R6");
        apply(32'h0, 32'h7FFF_FFFF, 2'd2, 5'd0, 32'd100, 1, 3'd3, 4'b0010, 1, "R6");
        // R7 rotates by 3, 32, 64
        apply(32'h0, 32'h0000_0004, 2'd3, 5'd0, 32'd3, 1, 3'd3, 4'b0000, 1, "R7");
        apply(32'h0, 32'h8000_0010, 2'd3, 5'd0, 32'd32, 1, 3'd3, 4'b0000, 1, "R7");
        apply(32'h0, 32'h0000_0010, 2'd3, 5'd0, 32'd64, 1, 3'd3, 4'b0010, 1, "R7");
        // R8 zero counts, and immediate rotate-through-carry
        for (int k = 0; k < 4; k++)
            apply(32'h0, 32'h8765_4321, 2'(k), 5'd0, 32'h0, 1, 3'd3, 4'b0010, 1, "R8");
        apply(32'h0, 32'h0000_0003, 2'd3, 5'd0, 0, 0, 3'd3, 4'b0010, 1, "R8");
        apply(32'h0, 32'h0000_0002, 2'd3, 5'd0, 0, 0, 3'd3, 4'b0000, 1, "R8");
        // R9 bitwise: C from shifter, V held
        apply(32'hFFFF_FFFF, 32'h0000_0004, 2'd3, 5'd3, 0, 0, 3'd0, 4'b0001, 1, "R9");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 2'd1, 5'd1, 0, 0, 3'd0, 4'b0000, 1, "R9");
        // R10 arithmetic: shifter carry discarded
        apply(32'h0000_0001, 32'h0000_0004, 2'd3, 5'd3, 0, 0, 3'd4, 4'b0000, 1, "R10");
        apply(32'h8000_0000, 32'h8000_0000, 2'd0, 5'd0, 0, 0, 3'd4, 4'b0000, 1, "R10");
        // R11 zero and negative
        apply(32'h1234_5678, 32'h1234_5678, 2'd0, 5'd0, 0, 0, 3'd6, 4'b0000, 1, "R11");
        apply(32'h0, 32'h1, 2'd0, 5'd0, 0, 0, 3'd6, 4'b0000, 1, "R11");
        // R12 hold with set_flags low
        apply(32'h0, 32'h0, 2'd0, 5'd0, 0, 0, 3'd6, 4'b1011, 0, "R12");
        apply(32'hFFFF_FFFF, 32'h1, 2'd0, 5'd0, 0, 0, 3'd4, 4'b0100, 0, "R12");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rg;
            logic [2:0]  op;
            bit          sf;
            string       tag;
            rg = {$urandom % 2 ? 24'($urandom) : 24'h0, pick_amt()[7:0]};
            op = 3'($urandom);
            sf = 1'($urandom);
            tag = !sf ? "R12" : ((op >= 3'd4 && op <= 3'd6) ? "R10" : "R9");
            apply($urandom, $urandom, 2'($urandom), 5'($urandom), rg, 1'($urandom),
                  op, 4'($urandom), sf, tag);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule